// File: doc/BRIEF.md
# Per-Pixel Offset and Gain Corrector

This block removes fixed-pattern errors from a stream of 12-bit image sensor samples, taking at most one sample per clock. Each sample arrives with its own 16-bit coefficient word, which an upstream coefficient fetcher supplies. The block splits the word into an offset and a gain. It subtracts the offset from the sample's upper ten bits, clamping at zero. It then scales the difference by the gain, clamping at full scale, and presents a 10-bit corrected pixel.

A split-mode input selects one of two layouts for the coefficient word. The first layout gives a narrow offset with a wide gain. The second gives a wider offset, for sensors with large dark offsets, at the cost of gain resolution. The mode is taken only when a line begins, so the layout cannot change in the middle of a line. The datapath is a two-stage pipeline, and a valid strobe travels alongside the data.

Top module: `pix_fpn_corrector`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid_o` is 0 and `pixel_o` is 0.
- R2: With effective split mode 0, the offset is coefficient bits [15:10] (6 bits, unsigned) and the gain is bits [9:0].
- R3: With effective split mode 1, the offset is coefficient bits [15:8] (8 bits, unsigned). The gain is bits [7:0] placed in the top 8 bits of a 10-bit gain value, with the two low bits set to zero.
- R4: Sample bits [1:0] have no effect. The offset is subtracted from sample bits [11:2], and one offset LSB equals one LSB of that 10-bit value.
- R5: When the offset exceeds sample bits [11:2], the difference is 0 rather than a wrapped value.
- R6: The gain is unsigned with 8 fractional bits: pixel = floor(difference × gain / 256), so a gain code of 256 passes the difference unchanged.
- R7: When the scaled result exceeds 1023, `pixel_o` is 1023.
- R8: `out_valid_o` equals `in_valid_i` delayed by exactly two clocks, and the pixel on `pixel_o` is the one from that same input.
- R9: The effective split mode is `mode_cfg_i` in a cycle where `line_start_i` is 1. Otherwise it is the value latched at the most recent line start, and it is 0 after reset. A change of `mode_cfg_i` in the middle of a line has no effect.
- R10: In a cycle where `out_valid_o` is 0, `pixel_o` keeps the last valid pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start_i | input | 1 | Marks the first pixel of a line; split mode is taken here |
| mode_cfg_i | input | 1 | Split mode: 0 = 6-bit offset / 10-bit gain, 1 = 8-bit offset / 8-bit gain |
| in_valid_i | input | 1 | Sample and coefficient are valid this cycle |
| sample_i | input | 12 | Raw ADC sample |
| coef_i | input | 16 | Coefficient word: offset field above, gain field below |
| out_valid_o | output | 1 | Corrected pixel valid |
| pixel_o | output | 10 | Corrected, saturated pixel |

## Verification
The hardest case to reach from the ports is a mode change in the middle of a line. It only shows up when the two layouts give different results for the same coefficient word, and a change at a line start looks almost the same from outside. The stimulus therefore uses one word whose narrow and wide decodes differ, and flips `mode_cfg_i` between line starts. The random lines also toggle the mode while `line_start_i` is low. The two saturation boundaries get directed samples: an offset above the sample, and a maximum gain on a near-full-scale difference.

// File: rtl/pfc_pkg.sv
// Package: shared types for the per-pixel corrector.
// Assumes nothing beyond standard SystemVerilog.
package pfc_pkg;
    // Layout of the coefficient word
    typedef enum logic {
        SPLIT_NARROW_OFS = 1'b0,
        SPLIT_WIDE_OFS   = 1'b1
    } split_mode_e;
endpackage

// File: rtl/pfc_coef_split.sv
// pfc_coef_split: combinational decode of one coefficient word into an
// offset and a PIX_W-bit gain. The offset sits in the upper bits and the
// gain in the lower bits.
// Assumes OFS_NARROW_W + PIX_W == COEF_W and OFS_WIDE_W <= PIX_W.
module pfc_coef_split #(
    parameter int COEF_W       = 16,
    parameter int PIX_W        = 10,
    parameter int OFS_NARROW_W = 6,
    parameter int OFS_WIDE_W   = 8
) (
    input  pfc_pkg::split_mode_e     mode_i,
    input  logic [COEF_W-1:0]        coef_i,
    output logic [OFS_WIDE_W-1:0]    offset_o,
    output logic [PIX_W-1:0]         gain_o
);
    localparam int GAIN_WIDE_W = COEF_W - OFS_WIDE_W;
    localparam int GAIN_PAD_W  = PIX_W - GAIN_WIDE_W;

    logic [OFS_NARROW_W-1:0] ofs_narrow;
    logic [OFS_WIDE_W-1:0]   ofs_wide;
    logic [PIX_W-1:0]        gain_narrow;
    logic [GAIN_WIDE_W-1:0]  gain_wide_raw;

    assign ofs_narrow    = coef_i[COEF_W-1 -: OFS_NARROW_W];
    assign ofs_wide      = coef_i[COEF_W-1 -: OFS_WIDE_W];
    assign gain_narrow   = coef_i[PIX_W-1:0];
    assign gain_wide_raw = coef_i[GAIN_WIDE_W-1:0];

    // Purpose: choose the field layout from the effective mode
    always_comb begin
        if (mode_i == pfc_pkg::SPLIT_WIDE_OFS) begin
            offset_o = ofs_wide;
            gain_o   = PIX_W'(gain_wide_raw) << GAIN_PAD_W;
        end else begin
            offset_o = OFS_WIDE_W'(ofs_narrow);
            gain_o   = gain_narrow;
        end
    end
endmodule

// File: rtl/pfc_sub_stage.sv
// pfc_sub_stage: pipeline stage 1. Subtracts the offset from the truncated
// sample, clamping at zero, and registers the difference, the gain and valid.
// Assumes OFS_W <= PIX_W.
module pfc_sub_stage #(
    parameter int PIX_W = 10,
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [PIX_W-1:0] sample_hi_i,
    input  logic [OFS_W-1:0] offset_i,
    input  logic [PIX_W-1:0] gain_i,
    output logic             valid_o,
    output logic [PIX_W-1:0] diff_o,
    output logic [PIX_W-1:0] gain_o
);
    logic [PIX_W-1:0] ofs_ext;
    logic [PIX_W-1:0] diff_d;

    assign ofs_ext = PIX_W'(offset_i);

    // Purpose: subtract with a floor at zero
    always_comb begin
        if (ofs_ext > sample_hi_i) diff_d = '0;
        else                       diff_d = sample_hi_i - ofs_ext;
    end

    // Purpose: stage-1 pipeline register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            diff_o  <= '0;
            gain_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                diff_o <= diff_d;
                gain_o <= gain_i;
            end
        end
    end

    // R5
    sub_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (PIX_W'(offset_i) > sample_hi_i)) |=> (diff_o == '0));

    // R4
    sub_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (PIX_W'(offset_i) <= sample_hi_i))
        |=> ((diff_o + PIX_W'($past(offset_i))) == $past(sample_hi_i)));
endmodule

// File: rtl/pfc_mul_stage.sv
// pfc_mul_stage: pipeline stage 2. Multiplies the difference by an unsigned
// gain with FRAC_W fractional bits, truncates, and clamps at full scale.
// Holds its output when no valid data arrives.
module pfc_mul_stage #(
    parameter int PIX_W  = 10,
    parameter int FRAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [PIX_W-1:0] diff_i,
    input  logic [PIX_W-1:0] gain_i,
    output logic             valid_o,
    output logic [PIX_W-1:0] pixel_o
);
    localparam int PROD_W = 2 * PIX_W;
    localparam logic [PIX_W-1:0] PIX_MAX = '1;
    localparam logic [PIX_W-1:0] UNITY   = PIX_W'(1) << FRAC_W;

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] scaled;
    logic [PIX_W-1:0]  pixel_d;

    assign product = PROD_W'(diff_i) * PROD_W'(gain_i);
    assign scaled  = product >> FRAC_W;

    // Purpose: clamp the scaled product at full scale
    always_comb begin
        if (|scaled[PROD_W-1:PIX_W]) pixel_d = PIX_MAX;
        else                         pixel_d = scaled[PIX_W-1:0];
    end

    // Purpose: stage-2 pipeline register, held while not valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            pixel_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) pixel_o <= pixel_d;
        end
    end

    // R6
    unity_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && gain_i == UNITY) |=> (pixel_o == $past(diff_i)));

    // R6
    zero_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && diff_i == '0) |=> (pixel_o == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pixel_o));
endmodule

// File: rtl/pix_fpn_corrector.sv
// pix_fpn_corrector: per-pixel offset/gain correction of a raw sample
// stream. The split mode is latched at line start and bypassed on the
// line-start pixel itself. Latency is two clocks.
// Assumes the coefficient word arrives in the same cycle as its sample.
module pix_fpn_corrector #(
    parameter int SAMPLE_W     = 12,
    parameter int PIX_W        = 10,
    parameter int COEF_W       = 16,
    parameter int OFS_NARROW_W = 6,
    parameter int OFS_WIDE_W   = 8,
    parameter int FRAC_W       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start_i,
    input  logic                mode_cfg_i,
    input  logic                in_valid_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [COEF_W-1:0]   coef_i,
    output logic                out_valid_o,
    output logic [PIX_W-1:0]    pixel_o
);
    import pfc_pkg::*;

    split_mode_e             mode_q;
    split_mode_e             mode_eff;
    logic [OFS_WIDE_W-1:0]   offset;
    logic [PIX_W-1:0]        gain;
    logic [PIX_W-1:0]        sample_hi;
    logic                    s1_valid;
    logic [PIX_W-1:0]        s1_diff;
    logic [PIX_W-1:0]        s1_gain;

    assign sample_hi = sample_i[SAMPLE_W-1 -: PIX_W];
    assign mode_eff  = line_start_i ? split_mode_e'(mode_cfg_i) : mode_q;

    // Purpose: latch the split mode at each line start
    always_ff @(posedge clk) begin
        if (!rst_n)            mode_q <= SPLIT_NARROW_OFS;
        else if (line_start_i) mode_q <= split_mode_e'(mode_cfg_i);
    end

    pfc_coef_split #(
        .COEF_W(COEF_W), .PIX_W(PIX_W),
        .OFS_NARROW_W(OFS_NARROW_W), .OFS_WIDE_W(OFS_WIDE_W)
    ) u_split (
        .mode_i(mode_eff), .coef_i(coef_i),
        .offset_o(offset), .gain_o(gain)
    );

    pfc_sub_stage #(.PIX_W(PIX_W), .OFS_W(OFS_WIDE_W)) u_sub (
        .clk(clk), .rst_n(rst_n), .valid_i(in_valid_i),
        .sample_hi_i(sample_hi), .offset_i(offset), .gain_i(gain),
        .valid_o(s1_valid), .diff_o(s1_diff), .gain_o(s1_gain)
    );

    pfc_mul_stage #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .valid_i(s1_valid),
        .diff_i(s1_diff), .gain_i(s1_gain),
        .valid_o(out_valid_o), .pixel_o(pixel_o)
    );

    // Purpose: count cycles since reset for the latency check
    logic [1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) |-> (out_valid_o == $past(in_valid_i, 2)));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_i |=> $stable(mode_q));
endmodule

// File: tb/tb_pix_fpn_corrector.sv
module tb_pix_fpn_corrector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start_i = 1'b0;
    logic        mode_cfg_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [11:0] sample_i = '0;
    logic [15:0] coef_i = '0;
    logic        out_valid_o;
    logic [9:0]  pixel_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit          bm_mode = 1'b0;
    bit          expv [2] = '{1'b0, 1'b0};
    int          expp [2] = '{0, 0};
    string       expt [2] = '{"R1", "R1"};
    int          held = 0;

    always #5 clk = ~clk;

    pix_fpn_corrector dut (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
        .mode_cfg_i(mode_cfg_i), .in_valid_i(in_valid_i),
        .sample_i(sample_i), .coef_i(coef_i),
        .out_valid_o(out_valid_o), .pixel_o(pixel_o)
    );

    // Expected pixel from R2-R7
    function automatic int model(bit m, logic [11:0] s, logic [15:0] c);
        int ofs, gn, hi, d, p;
        if (m) begin ofs = int'(c[15:8]);  gn = int'(c[7:0]) * 4; end
        else   begin ofs = int'(c[15:10]); gn = int'(c[9:0]);     end
        hi = int'(s[11:2]);
        d  = (ofs > hi) ? 0 : hi - ofs;
        p  = (d * gn) / 256;
        return (p > 1023) ? 1023 : p;
    endfunction

    task automatic check_out();
        n_chk++;
        if (out_valid_o !== expv[1]) begin
            n_fail++;
            $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid_o, expv[1]);
        end
        n_chk++;
        if (expv[1]) begin
            if (int'(pixel_o) != expp[1]) begin
                n_fail++;
                $display("FAIL %s pixel actual=%0d expected=%0d", expt[1], pixel_o, expp[1]);
            end
            held = expp[1];
        end else if (int'(pixel_o) != held) begin
            n_fail++;
            $display("FAIL R10 held pixel actual=%0d expected=%0d", pixel_o, held);
        end
    endtask

    task automatic step(bit v, bit ls, bit m, logic [11:0] s, logic [15:0] c, string tag);
        @(negedge clk);
        check_out();
        if (ls) bm_mode = m;
        expv[1] = expv[0]; expp[1] = expp[0]; expt[1] = expt[0];
        expv[0] = v;       expp[0] = model(bm_mode, s, c); expt[0] = tag;
        in_valid_i = v; line_start_i = ls; mode_cfg_i = m;
        sample_i = s; coef_i = c;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        n_chk++;
        if (out_valid_o !== 1'b0 || pixel_o !== 10'd0) begin
            n_fail++;
            $display("FAIL R1 reset actual=%0b/%0d expected=0/0", out_valid_o, pixel_o);
        end
        rst_n = 1'b1;

        // R2, R6: mode 0, offset 5, unity gain, hi=100 -> 95
        step(1, 1, 0, 12'(100 << 2), {6'd5, 10'd256}, "R2");
        // R4: low sample bits ignored, same result
        step(1, 0, 0, 12'((100 << 2) | 3), {6'd5, 10'd256}, "R4");
        // R5: offset 63 above hi=10 -> 0
        step(1, 0, 0, 12'(10 << 2), {6'd63, 10'd300}, "R5");
        // R7: 1023*1023/256 clamps to 1023
        step(1, 0, 0, 12'hFFF, {6'd0, 10'd1023}, "R7");
        // R6: half gain, hi=200 off=0 -> 100
        step(1, 0, 0, 12'(200 << 2), {6'd0, 10'd128}, "R6");
        // R10: bubble then keep checking
        step(0, 0, 0, 12'hABC, 16'hFFFF, "R10");
        // R3: mode 1, off 128, gain 0x40 -> 256; hi=300 -> 172
        step(1, 1, 1, 12'(300 << 2), {8'd128, 8'h40}, "R3");
        // R9: mode 0 line, mid-line flip; coef 0xFC40 hi=500 -> 109 not 248
        step(1, 1, 0, 12'(500 << 2), 16'hFC40, "R9");
        step(1, 0, 1, 12'(500 << 2), 16'hFC40, "R9");
        step(1, 0, 1, 12'(500 << 2), 16'hFC40, "R9");
        // R9: next line start takes mode 1 -> 248
        step(1, 1, 1, 12'(500 << 2), 16'hFC40, "R9");

        // Random lines with mid-line mode toggles
        for (int i = 0; i < 4000; i++) begin
            bit ls, v, m;
            ls = (i % 37 == 0);
            v  = ($urandom_range(0, 9) < 8);
            m  = bit'($urandom_range(0, 1));
            step(v, ls, m, 12'($urandom), 16'($urandom), "R6");
        end
        step(0, 0, 0, '0, '0, "R8");
        step(0, 0, 0, '0, '0, "R8");
        step(0, 0, 0, '0, '0, "R8");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule